// File: doc/BRIEF.md
# Serial Bitstream Receiver

This block is the input stage in front of a compressed-audio decoder. It watches two sets of three-wire serial lines. Each set has a bit clock, an identification line and a data line. The block picks one set as the active source and turns the serial bits into 16-bit parallel words for the decoder. All serial lines are first brought into the fast system clock domain. The block acts on each falling edge of the active bit clock, and the data line is sampled at that edge.

A small register write port stands in for the control bus. It selects the source and carries the start-up sequence. Until that sequence has been accepted, the block emits no words. The sequence is a configuration write followed by a run command. Both writes count only while the active bit clock is low. A synchronous reset discards the accepted sequence, so the sequence must be given again after every reset.

Top module: `serial_bitstream_rx`

## Requirements
- R1: After reset, `word_valid` and `ident_err` are 0, the primary source is selected and the block is not started.
- R2: Before the start-up sequence has been accepted, falling edges on the active bit clock produce no word.
- R3: The start-up sequence is two register writes, in this order:
  - a write of 0x0020 to address 0x3B;
  - a write of 0x0001 to address 0x6A.

  Once both have been accepted, the block packs serial bits. A write of any other value to 0x3B cancels a pending configuration write.
- R4: A start-up write made while the synchronized active bit clock is high is not counted.
- R5: A run command with no accepted configuration write before it does not start the block.
- R6: On each falling edge of the active bit clock, the data line is sampled. The first bit received goes to bit 15 and the rest follow in arrival order. After 16 bits, the word appears on `word_data` with a single-cycle `word_valid` pulse.
- R7: A write to address 0x4F selects the source:
  - value 0 selects the primary lines;
  - value 2 selects the alternate lines.

  The lines of the source that is not selected have no effect.
- R8: A write of any other value to address 0x4F is ignored, and the current selection is kept.
- R9: Changing the selected source discards any partly assembled word.
- R10: If the identification line is high at a falling edge of the bit clock, that bit is dropped, and `ident_err` pulses for one cycle.
- R11: A reset pulse clears the started state. Words resume only after the full start-up sequence is given again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register write address |
| reg_wdata | input | 16 | Register write data |
| pri_sclk | input | 1 | Primary bit clock |
| pri_sid | input | 1 | Primary identification line |
| pri_sdat | input | 1 | Primary data line |
| alt_sclk | input | 1 | Alternate bit clock |
| alt_sid | input | 1 | Alternate identification line |
| alt_sdat | input | 1 | Alternate data line |
| word_data | output | 16 | Assembled word |
| word_valid | output | 1 | One-cycle strobe for a new word |
| ident_err | output | 1 | Pulse for a bit dropped because the identification line was high |

## Verification
The bench targets the start-up gating in several ways:
- It gives a correct sequence while the bit clock is held high. A design that ignores the clock level would start early and emit words.
- It gives a run command with no configuration write, and a configuration write with the wrong value. A design that skips either check would start when it should not.
- It switches sources in the middle of a word. A design that keeps the partial bits would output a word shifted by those stale bits.
- It sends a bit with the identification line high. A design that does not drop that bit would misalign every word that follows.
- It writes illegal select values. A design that accepts them would switch away from the lines carrying the data.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 16;

  localparam logic [ADDR_W-1:0] ADDR_SRC = 8'h4F;
  localparam logic [ADDR_W-1:0] ADDR_CFG = 8'h3B;
  localparam logic [ADDR_W-1:0] ADDR_CMD = 8'h6A;

  localparam logic [REG_W-1:0] CFG_START_VAL = 16'h0020;
  localparam logic [REG_W-1:0] CMD_RUN_VAL   = 16'h0001;
  localparam logic [REG_W-1:0] SRC_PRI_VAL   = 16'h0000;
  localparam logic [REG_W-1:0] SRC_ALT_VAL   = 16'h0002;

  typedef struct packed {
    logic bclk;
    logic ident;
    logic data;
  } sbi_lines_t;
endpackage

// File: rtl/sbi_line_sync.sv
module sbi_line_sync
  import sbi_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  sbi_lines_t raw,
  output sbi_lines_t synced,
  output logic       bclk_fall
);
  sbi_lines_t stage_q [STAGES];
  logic       bclk_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      bclk_prev_q <= 1'b0;
    end else begin
      stage_q[0] <= raw;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      bclk_prev_q <= stage_q[STAGES-1].bclk;
    end
  end

  assign synced    = stage_q[STAGES-1];
  assign bclk_fall = bclk_prev_q & ~stage_q[STAGES-1].bclk;
endmodule

// File: rtl/sbi_ctrl.sv
module sbi_ctrl
  import sbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  input  logic              bclk_lvl,
  output logic              sel_alt,
  output logic              sel_chg,
  output logic              run_en
);
  logic cfg_ok_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_alt  <= 1'b0;
      sel_chg  <= 1'b0;
      cfg_ok_q <= 1'b0;
      run_en   <= 1'b0;
    end else begin
      sel_chg <= 1'b0;
      if (we) begin
        case (addr)
          ADDR_SRC: begin
            if (wdata == SRC_PRI_VAL && sel_alt) begin
              sel_alt <= 1'b0;
              sel_chg <= 1'b1;
            end else if (wdata == SRC_ALT_VAL && !sel_alt) begin
              sel_alt <= 1'b1;
              sel_chg <= 1'b1;
            end
          end
          ADDR_CFG: begin
            if (!bclk_lvl) cfg_ok_q <= (wdata == CFG_START_VAL);
          end
          ADDR_CMD: begin
            if (!bclk_lvl && cfg_ok_q && wdata == CMD_RUN_VAL) run_en <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  assert_src_keep_R8: assert property (@(posedge clk) disable iff (rst)
    (we && addr == ADDR_SRC && wdata != SRC_PRI_VAL && wdata != SRC_ALT_VAL) |=> $stable(sel_alt));

  assert_start_low_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(run_en) |-> $past(we && addr == ADDR_CMD && !bclk_lvl));

  assert_run_sticky_R3: assert property (@(posedge clk) disable iff (rst)
    run_en |=> run_en);
endmodule

// File: rtl/sbi_packer.sv
module sbi_packer #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_fall,
  input  logic              bit_data,
  input  logic              bit_ident,
  input  logic              enable,
  input  logic              clear,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              ident_err
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q    <= '0;
      cnt_q      <= '0;
      word_data  <= '0;
      word_valid <= 1'b0;
      ident_err  <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      ident_err  <= 1'b0;
      if (clear) begin
        cnt_q <= '0;
      end else if (bit_fall && enable) begin
        if (bit_ident) begin
          ident_err <= 1'b1;
        end else begin
          shift_q <= {shift_q[WORD_W-2:0], bit_data};
          if (cnt_q == LAST) begin
            word_data  <= {shift_q[WORD_W-2:0], bit_data};
            word_valid <= 1'b1;
            cnt_q      <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);

  assert_drop_excl_R10: assert property (@(posedge clk) disable iff (rst)
    ident_err |-> !word_valid);

  assert_clear_R9: assert property (@(posedge clk) disable iff (rst)
    clear |=> (cnt_q == '0 && !word_valid));

  assert_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_fall && !enable) |=> !word_valid);
endmodule

// File: rtl/serial_bitstream_rx.sv
module serial_bitstream_rx
  import sbi_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              pri_sclk,
  input  logic              pri_sid,
  input  logic              pri_sdat,
  input  logic              alt_sclk,
  input  logic              alt_sid,
  input  logic              alt_sdat,
  output logic [WORD_W-1:0] word_data,
  output logic              word_valid,
  output logic              ident_err
);
  localparam int NSRC = 2;

  sbi_lines_t raw    [NSRC];
  sbi_lines_t synced [NSRC];
  logic       fall   [NSRC];

  assign raw[0] = '{bclk: pri_sclk, ident: pri_sid, data: pri_sdat};
  assign raw[1] = '{bclk: alt_sclk, ident: alt_sid, data: alt_sdat};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    sbi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst       (rst),
      .raw       (raw[g]),
      .synced    (synced[g]),
      .bclk_fall (fall[g])
    );
  end

  logic       sel_alt, sel_chg, run_en;
  sbi_lines_t act;
  logic       act_fall;

  assign act      = sel_alt ? synced[1] : synced[0];
  assign act_fall = sel_alt ? fall[1]   : fall[0];

  sbi_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .we       (reg_we),
    .addr     (reg_addr),
    .wdata    (reg_wdata),
    .bclk_lvl (act.bclk),
    .sel_alt  (sel_alt),
    .sel_chg  (sel_chg),
    .run_en   (run_en)
  );

  sbi_packer #(.WORD_W(WORD_W)) u_pack (
    .clk        (clk),
    .rst        (rst),
    .bit_fall   (act_fall),
    .bit_data   (act.data),
    .bit_ident  (act.ident),
    .enable     (run_en),
    .clear      (sel_chg),
    .word_data  (word_data),
    .word_valid (word_valid),
    .ident_err  (ident_err)
  );
endmodule

// File: tb/serial_bitstream_rx_test.sv
module serial_bitstream_rx_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic pri_c = 0, pri_i = 0, pri_d = 0, alt_c = 0, alt_i = 0, alt_d = 0;
  logic [15:0] word_data;
  logic        word_valid, ident_err;

  int checks = 0, errors = 0, nwords = 0, nerr = 0, cur_src = 0;
  logic [15:0] last_word = '0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bitstream_rx uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pri_sclk(pri_c), .pri_sid(pri_i), .pri_sdat(pri_d),
    .alt_sclk(alt_c), .alt_sid(alt_i), .alt_sdat(alt_d),
    .word_data(word_data), .word_valid(word_valid), .ident_err(ident_err)
  );

  always @(negedge clk) begin
    if (word_valid) begin nwords++; last_word = word_data; end
    if (ident_err) nerr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive_src(input logic c, input logic i, input logic d);
    if (cur_src == 0) begin
      pri_c = c; pri_i = i; pri_d = d;
      alt_c = ~c; alt_i = 1'($urandom); alt_d = 1'($urandom);
    end else begin
      alt_c = c; alt_i = i; alt_d = d;
      pri_c = ~c; pri_i = 1'($urandom); pri_d = 1'($urandom);
    end
  endtask

  task automatic send_bit(input logic b, input logic id);
    drive_src(1'b1, id, b);
    repeat (4) @(negedge clk);
    drive_src(1'b0, id, b);
    repeat (4) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    for (int i = 15; i >= 0; i--) send_bit(w[i], 1'b0);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [15:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic start_seq();
    reg_write(8'h3B, 16'h0020);
    reg_write(8'h6A, 16'h0001);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cur_src = 0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    void'($urandom(32'h5eed));
    @(negedge clk);
    do_reset();
    chk("R1 valid after reset", 32'(word_valid), 0);
    chk("R1 ident_err after reset", 32'(ident_err), 0);

    nwords = 0;
    send_word(16'hFFFF);
    chk("R2 no words before start", nwords, 0);

    pri_c = 1'b1;
    repeat (4) @(negedge clk);
    start_seq();
    pri_c = 1'b0;
    repeat (4) @(negedge clk);
    nwords = 0;
    send_word(16'h1234);
    chk("R4 start while clock high ignored", nwords, 0);

    reg_write(8'h6A, 16'h0001);
    nwords = 0;
    send_word(16'h4321);
    chk("R5 run alone does not start", nwords, 0);
    reg_write(8'h3B, 16'h0021);
    reg_write(8'h6A, 16'h0001);
    nwords = 0;
    send_word(16'h5555);
    chk("R5 wrong config value does not start", nwords, 0);

    start_seq();
    nwords = 0;
    send_word(16'hA5C3);
    chk("R3 word count after start", nwords, 1);
    chk("R3 R6 MSB-first word", last_word, 16'hA5C3);

    for (int k = 0; k < 20; k++) begin
      w = 16'($urandom);
      nwords = 0;
      send_word(w);
      chk("R6 random word count", nwords, 1);
      chk("R6 random word value", last_word, w);
    end

    reg_write(8'h4F, 16'h0002);
    cur_src = 1;
    for (int k = 0; k < 5; k++) begin
      w = 16'($urandom);
      nwords = 0;
      send_word(w);
      chk("R7 alternate word count", nwords, 1);
      chk("R7 alternate word value", last_word, w);
    end

    reg_write(8'h4F, 16'h0001);
    reg_write(8'h4F, 16'h0003);
    nwords = 0;
    send_word(16'hBEEF);
    chk("R8 illegal select kept alternate", last_word, 16'hBEEF);
    chk("R8 illegal select word count", nwords, 1);

    for (int i = 0; i < 7; i++) send_bit(1'b1, 1'b0);
    reg_write(8'h4F, 16'h0000);
    cur_src = 0;
    nwords = 0;
    send_word(16'h0F0F);
    chk("R9 partial word discarded count", nwords, 1);
    chk("R9 partial word discarded value", last_word, 16'h0F0F);

    w = 16'($urandom);
    nwords = 0; nerr = 0;
    for (int i = 15; i >= 8; i--) send_bit(w[i], 1'b0);
    send_bit(~w[7], 1'b1);
    for (int i = 7; i >= 0; i--) send_bit(w[i], 1'b0);
    chk("R10 ident_err pulses", nerr, 1);
    chk("R10 dropped bit word", last_word, w);
    chk("R10 word count", nwords, 1);

    do_reset();
    nwords = 0;
    send_word(16'h7777);
    chk("R11 no words after reset", nwords, 0);
    start_seq();
    nwords = 0;
    send_word(16'hC001);
    chk("R11 R1 restart on primary", last_word, 16'hC001);
    chk("R11 restart word count", nwords, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule